// File: doc/BRIEF.md
# TL-UL Request Legality Gate

This block stands between a TL-UL device port and a register file with attached memory windows. Every request the host presents is screened in the cycle it is accepted. The screen applies two sets of rules. The bus rules cover the opcode, the transfer size, address alignment and the byte mask. The device rules cover the address map, register write width and alignment, window access permissions and instruction-type writes. A request that passes reaches the device interface in its acceptance cycle. A request that fails never reaches it, and the host still receives a response with the error flag raised and zero data.

Exactly one transaction may be in flight. After a request is accepted, the gate lowers its ready output until the host takes the response. Back-to-back requests, including repeated requests to one address, are therefore served strictly one at a time. The default map has eight registers at byte addresses 0x000 to 0x01F. Registers 0 to 3 are four bytes wide and registers 4 to 7 are two bytes wide. A read-only window lies at 0x100 to 0x13F, and a write-only window without partial-write support lies at 0x200 to 0x23F.

Top module: `tlul_req_gate`

## Requirements
- R1: The legal opcodes are Get (4), PutFullData (0) and PutPartialData (1), and any other opcode is flagged as an error. The response opcode is AccessAckData (1) for Get and AccessAck (0) for every other opcode, whether the request is legal or not.
- R2: A request whose size field is 3 (wider than four bytes) is flagged as an error.
- R3: The address must be aligned to the transfer size. With size 1, address bit 0 must be zero. With size 2, address bits 1:0 must be zero. Otherwise the request is an error.
- R4: Mask bit i stands for byte lane i. A mask bit set outside the lanes selected by address bits 1:0 and the size is an error. For example, address 0x000 with size 0 and mask 0010 is an error, and so is address 0x001 with mask 0001.
- R5: A PutFullData whose mask does not equal the selected lanes exactly is an error.
- R6: An address that hits neither a register nor a window is an error. Addresses 0x020, 0x040, 0x140 and 0x300 are all unmapped.
- R7: A register write is an error if its address bits 1:0 are nonzero. It is also an error if its mask does not enable every byte of the register: mask 1111 for registers 0 to 3, and mask bits 1:0 for registers 4 to 7.
- R8: Each of the following is an error: a write to the read-only window, a read of the write-only window, a write to the write-only window whose mask is not 1111, and any write with the instruction-type flag set. A Get with the instruction-type flag set is legal.
- R9: An illegal request leaves dev_req_o low and receives a response with d_error_o high and d_data_o zero.
- R10: A legal request drives dev_req_o high in its acceptance cycle, together with the address, write enable, write data and byte enables. The byte enables are the mask for a write and 1111 for a read. A legal read returns the full 32-bit word from dev_rdata_i, whatever the mask. A write response carries zero data.
- R11: d_valid_o rises in the cycle after acceptance. The response holds with stable contents until d_ready_i is high.
- R12: a_ready_o is high after reset. It is low from acceptance until the response handshake, and high again in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request accepted when high with a_valid_i |
| a_opcode_i | input | 3 | Request opcode |
| a_size_i | input | 2 | Log2 of transfer bytes |
| a_mask_i | input | 4 | Byte lane mask |
| a_address_i | input | 12 | Byte address |
| a_data_i | input | 32 | Write data |
| a_source_i | input | 8 | Request tag, echoed in response |
| a_instr_i | input | 1 | Instruction-type flag |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Host takes response |
| d_opcode_o | output | 3 | Response opcode |
| d_error_o | output | 1 | Response error flag |
| d_data_o | output | 32 | Response read data |
| d_source_o | output | 8 | Echoed request tag |
| dev_req_o | output | 1 | Legal access strobe to the device |
| dev_we_o | output | 1 | Device write enable |
| dev_addr_o | output | 12 | Device byte address |
| dev_be_o | output | 4 | Device byte enables |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data, combinational on dev_addr_o |

## Verification
The device strobe and its address, enables and data are combinational in the acceptance cycle. The bench samples them one time unit after it drives the request at the falling edge, before the accepting rising edge. The response fields appear one register later, so the bench checks d_valid_o, d_error_o, d_opcode_o and d_data_o at the next falling edge. With d_ready_i held high, a_ready_o returns at the falling edge after that. Under back-pressure, the bench checks at each falling edge that the response stays stable and that a waiting second request gets neither the ready output nor the device strobe. It then checks that the second request is taken in the cycle after the handshake.

// File: rtl/tlg_pkg.sv
package tlg_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;

  typedef struct packed {
    logic bad_op;
    logic bad_size;
    logic bad_align;
    logic bad_mask;
    logic bad_full;
  } proto_err_t;

  // byte lanes covered by a transfer of 2**sz bytes at low address lo
  function automatic logic [3:0] lane_sel(input logic [1:0] sz, input logic [1:0] lo);
    logic [3:0] l;
    case (sz)
      2'd0:    l = 4'b0001 << lo;
      2'd1:    l = lo[1] ? 4'b1100 : 4'b0011;
      default: l = 4'b1111;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/tlg_proto_chk.sv
module tlg_proto_chk
  import tlg_pkg::*;
(
  input  logic [2:0] opcode_i,
  input  logic [1:0] size_i,
  input  logic [3:0] mask_i,
  input  logic [1:0] addr_lo_i,
  output logic       is_rd_o,
  output proto_err_t err_o
);
  logic [3:0] lanes;

  always_comb begin
    lanes           = lane_sel(size_i, addr_lo_i);
    is_rd_o         = (opcode_i == OP_GET);
    err_o.bad_op    = !(opcode_i == OP_GET || opcode_i == OP_PUT_FULL ||
                        opcode_i == OP_PUT_PART);
    err_o.bad_size  = (size_i > 2'd2);
    err_o.bad_align = (size_i == 2'd1 && addr_lo_i[0]) ||
                      (size_i == 2'd2 && addr_lo_i != 2'd0);
    err_o.bad_mask  = |(mask_i & ~lanes);
    err_o.bad_full  = (opcode_i == OP_PUT_FULL) && (mask_i != lanes);
  end
endmodule

// File: rtl/tlg_map_chk.sv
module tlg_map_chk #(
  parameter int unsigned AW          = 12,
  parameter int unsigned NUM_REGS    = 8,
  parameter logic [NUM_REGS-1:0] REG_WIDE = 8'b0000_1111,
  parameter int unsigned NARROW_BYTES = 2,
  parameter int unsigned NUM_WIN     = 2,
  parameter int unsigned WIN_AW      = 6,
  parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {12'h200, 12'h100},
  parameter logic [NUM_WIN-1:0] WIN_RD   = 2'b01,
  parameter logic [NUM_WIN-1:0] WIN_WR   = 2'b10,
  parameter logic [NUM_WIN-1:0] WIN_PART = 2'b00
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_wr_i,
  input  logic [3:0]    mask_i,
  input  logic          instr_i,
  output logic          err_o
);
  localparam int unsigned RIW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [AW-3:0] REG_LIM = (AW-2)'(NUM_REGS);
  localparam logic [3:0] NARROW_NEED = 4'hF >> (4 - NARROW_BYTES);

  logic               reg_hit;
  logic [RIW-1:0]     reg_idx;
  logic [3:0]         need;
  logic [NUM_WIN-1:0] win_hit;
  logic [NUM_WIN-1:0] win_deny;
  logic               reg_err;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign win_hit[i]  = (addr_i[AW-1:WIN_AW] == WIN_BASE[i][AW-1:WIN_AW]);
    assign win_deny[i] = is_wr_i ? (!WIN_WR[i] || (!WIN_PART[i] && mask_i != 4'hF))
                                 : !WIN_RD[i];
  end

  always_comb begin
    reg_hit = (addr_i[AW-1:2] < REG_LIM);
    reg_idx = addr_i[RIW+1:2];
    need    = REG_WIDE[reg_idx] ? 4'hF : NARROW_NEED;
    reg_err = reg_hit && is_wr_i &&
              (addr_i[1:0] != 2'd0 || (mask_i & need) != need);
    err_o   = (!reg_hit && !(|win_hit)) || reg_err ||
              (|(win_hit & win_deny)) || (instr_i && is_wr_i);
  end
endmodule

// File: rtl/tlg_rsp.sv
module tlg_rsp
  import tlg_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned SRC = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  logic           err_i,
  input  logic           rd_i,
  input  logic [DW-1:0]  rdata_i,
  input  logic [SRC-1:0] src_i,
  input  logic           d_ready_i,
  output logic           d_valid_o,
  output logic [2:0]     d_opcode_o,
  output logic           d_error_o,
  output logic [DW-1:0]  d_data_o,
  output logic [SRC-1:0] d_source_o,
  output logic           busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= RSP_ACK;
      d_error_o  <= 1'b0;
      d_data_o   <= '0;
      d_source_o <= '0;
    end else if (accept_i) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= rd_i ? RSP_ACK_DATA : RSP_ACK;
      d_error_o  <= err_i;
      d_data_o   <= (rd_i && !err_i) ? rdata_i : '0;
      d_source_o <= src_i;
    end else if (d_valid_o && d_ready_i) begin
      d_valid_o  <= 1'b0;
    end
  end

  assign busy_o = d_valid_o;

  // R11
  rsp_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> d_valid_o);
  // R11
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && !d_ready_i |=> d_valid_o && $stable(d_data_o) && $stable(d_error_o)
                                && $stable(d_opcode_o));
  // R12
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !d_valid_o);
  // R9
  err_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && d_error_o |-> d_data_o == '0);
endmodule

// File: rtl/tlul_req_gate.sv
module tlul_req_gate
  import tlg_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32,
  parameter int unsigned SRC = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a_valid_i,
  output logic           a_ready_o,
  input  logic [2:0]     a_opcode_i,
  input  logic [1:0]     a_size_i,
  input  logic [3:0]     a_mask_i,
  input  logic [AW-1:0]  a_address_i,
  input  logic [DW-1:0]  a_data_i,
  input  logic [SRC-1:0] a_source_i,
  input  logic           a_instr_i,
  output logic           d_valid_o,
  input  logic           d_ready_i,
  output logic [2:0]     d_opcode_o,
  output logic           d_error_o,
  output logic [DW-1:0]  d_data_o,
  output logic [SRC-1:0] d_source_o,
  output logic           dev_req_o,
  output logic           dev_we_o,
  output logic [AW-1:0]  dev_addr_o,
  output logic [3:0]     dev_be_o,
  output logic [DW-1:0]  dev_wdata_o,
  input  logic [DW-1:0]  dev_rdata_i
);
  proto_err_t perr;
  logic is_rd, map_err, err, accept, busy;

  tlg_proto_chk u_proto (
    .opcode_i  (a_opcode_i),
    .size_i    (a_size_i),
    .mask_i    (a_mask_i),
    .addr_lo_i (a_address_i[1:0]),
    .is_rd_o   (is_rd),
    .err_o     (perr)
  );

  tlg_map_chk #(.AW(AW)) u_map (
    .addr_i  (a_address_i),
    .is_wr_i (!is_rd),
    .mask_i  (a_mask_i),
    .instr_i (a_instr_i),
    .err_o   (map_err)
  );

  assign a_ready_o   = !busy;
  assign accept      = a_valid_i && a_ready_o;
  assign err         = (|perr) || map_err;
  assign dev_req_o   = accept && !err;
  assign dev_we_o    = !is_rd;
  assign dev_addr_o  = a_address_i;
  assign dev_be_o    = is_rd ? 4'hF : a_mask_i;
  assign dev_wdata_o = a_data_i;

  tlg_rsp #(.DW(DW), .SRC(SRC)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .err_i      (err),
    .rd_i       (is_rd),
    .rdata_i    (dev_rdata_i),
    .src_i      (a_source_i),
    .d_ready_i  (d_ready_i),
    .d_valid_o  (d_valid_o),
    .d_opcode_o (d_opcode_o),
    .d_error_o  (d_error_o),
    .d_data_o   (d_data_o),
    .d_source_o (d_source_o),
    .busy_o     (busy)
  );

  // R10
  legal_rsp_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o |=> d_valid_o && !d_error_o);
  // R2
  wide_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && a_size_i == 2'd3 |=> d_error_o);
  // R1
  bad_opcode_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !(a_opcode_i == OP_GET || a_opcode_i == OP_PUT_FULL ||
                a_opcode_i == OP_PUT_PART) |=> d_error_o && d_opcode_o == RSP_ACK);
endmodule

// File: tb/tlul_req_gate_test.sv
module tlul_req_gate_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_valid = 1'b0, a_ready;
  logic [2:0]  a_opcode = 3'd4;
  logic [1:0]  a_size = 2'd2;
  logic [3:0]  a_mask = 4'hF;
  logic [11:0] a_address = '0;
  logic [31:0] a_data = '0;
  logic [7:0]  a_source = '0;
  logic        a_instr = 1'b0;
  logic        d_valid, d_ready = 1'b1, d_error;
  logic [2:0]  d_opcode;
  logic [31:0] d_data;
  logic [7:0]  d_source;
  logic        dev_req, dev_we;
  logic [11:0] dev_addr;
  logic [3:0]  dev_be;
  logic [31:0] dev_wdata, dev_rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign dev_rdata = {8'h5A, 12'h3C3, dev_addr};

  tlul_req_gate uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_opcode_i(a_opcode),
    .a_size_i(a_size), .a_mask_i(a_mask), .a_address_i(a_address),
    .a_data_i(a_data), .a_source_i(a_source), .a_instr_i(a_instr),
    .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode),
    .d_error_o(d_error), .d_data_o(d_data), .d_source_o(d_source),
    .dev_req_o(dev_req), .dev_we_o(dev_we), .dev_addr_o(dev_addr),
    .dev_be_o(dev_be), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [3:0]  mask;
    logic [11:0] addr;
    logic        instr;
    logic        err;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 2'd2, 4'hF, 12'h004, 1'b0, 1'b0, 4'd10},
    '{3'd4, 2'd0, 4'h2, 12'h001, 1'b0, 1'b0, 4'd10},
    '{3'd0, 2'd2, 4'hF, 12'h008, 1'b0, 1'b0, 4'd10},
    '{3'd1, 2'd2, 4'h3, 12'h010, 1'b0, 1'b0, 4'd7},
    '{3'd1, 2'd2, 4'h7, 12'h010, 1'b0, 1'b0, 4'd5},
    '{3'd4, 2'd2, 4'hF, 12'h104, 1'b0, 1'b0, 4'd8},
    '{3'd0, 2'd2, 4'hF, 12'h208, 1'b0, 1'b0, 4'd8},
    '{3'd4, 2'd2, 4'hF, 12'h000, 1'b1, 1'b0, 4'd8},
    '{3'd4, 2'd2, 4'hF, 12'h01C, 1'b0, 1'b0, 4'd6},
    '{3'd4, 2'd2, 4'hF, 12'h13C, 1'b0, 1'b0, 4'd6},
    '{3'd2, 2'd2, 4'hF, 12'h004, 1'b0, 1'b1, 4'd1},
    '{3'd7, 2'd2, 4'hF, 12'h004, 1'b0, 1'b1, 4'd1},
    '{3'd4, 2'd3, 4'hF, 12'h000, 1'b0, 1'b1, 4'd2},
    '{3'd4, 2'd1, 4'h3, 12'h001, 1'b0, 1'b1, 4'd3},
    '{3'd4, 2'd2, 4'hF, 12'h002, 1'b0, 1'b1, 4'd3},
    '{3'd4, 2'd0, 4'h2, 12'h000, 1'b0, 1'b1, 4'd4},
    '{3'd4, 2'd0, 4'h1, 12'h001, 1'b0, 1'b1, 4'd4},
    '{3'd0, 2'd2, 4'h7, 12'h010, 1'b0, 1'b1, 4'd5},
    '{3'd4, 2'd2, 4'hF, 12'h040, 1'b0, 1'b1, 4'd6},
    '{3'd0, 2'd2, 4'hF, 12'h300, 1'b0, 1'b1, 4'd6},
    '{3'd4, 2'd2, 4'hF, 12'h020, 1'b0, 1'b1, 4'd6},
    '{3'd4, 2'd2, 4'hF, 12'h140, 1'b0, 1'b1, 4'd6},
    '{3'd1, 2'd0, 4'h2, 12'h001, 1'b0, 1'b1, 4'd7},
    '{3'd1, 2'd2, 4'h3, 12'h000, 1'b0, 1'b1, 4'd7},
    '{3'd0, 2'd2, 4'hF, 12'h100, 1'b0, 1'b1, 4'd8},
    '{3'd4, 2'd2, 4'hF, 12'h200, 1'b0, 1'b1, 4'd8},
    '{3'd1, 2'd2, 4'h3, 12'h200, 1'b0, 1'b1, 4'd8},
    '{3'd0, 2'd2, 4'hF, 12'h004, 1'b1, 1'b1, 4'd9}
  };

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic [3:0] m,
                       input logic [11:0] ad, input logic ins);
    a_valid = 1'b1; a_opcode = op; a_size = sz; a_mask = m; a_address = ad;
    a_instr = ins; a_data = {20'hBEEF0, ad}; a_source = ad[7:0];
  endtask

  task automatic run_vec(input vec_t v);
    string t;
    logic [31:0] exp_data;
    t = tname(v.tag);
    exp_data = (v.op == 3'd4 && !v.err) ? {8'h5A, 12'h3C3, v.addr} : 32'h0;
    @(negedge clk);
    drive(v.op, v.sz, v.mask, v.addr, v.instr);
    d_ready = 1'b1;
    #1;
    chk(a_ready == 1'b1, "R12", "ready before request", {31'b0, a_ready}, 32'h1);
    chk(dev_req == !v.err, v.err ? "R9" : t, "dev_req", {31'b0, dev_req}, {31'b0, !v.err});
    if (!v.err) begin
      chk(dev_be == ((v.op == 3'd4) ? 4'hF : v.mask), "R10", "dev_be",
          {28'b0, dev_be}, {28'b0, (v.op == 3'd4) ? 4'hF : v.mask});
      chk(dev_we == (v.op != 3'd4), "R10", "dev_we", {31'b0, dev_we}, {31'b0, v.op != 3'd4});
      if (v.op != 3'd4)
        chk(dev_wdata == {20'hBEEF0, v.addr}, "R10", "dev_wdata", dev_wdata, {20'hBEEF0, v.addr});
    end
    @(negedge clk);
    a_valid = 1'b0;
    #1;
    chk(d_valid == 1'b1, "R11", "d_valid", {31'b0, d_valid}, 32'h1);
    chk(d_error == v.err, t, "d_error", {31'b0, d_error}, {31'b0, v.err});
    chk(d_opcode == ((v.op == 3'd4) ? 3'd1 : 3'd0), "R1", "d_opcode",
        {29'b0, d_opcode}, {29'b0, (v.op == 3'd4) ? 3'd1 : 3'd0});
    chk(d_data == exp_data, v.err ? "R9" : "R10", "d_data", d_data, exp_data);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(a_ready == 1'b1, "R12", "reset ready", {31'b0, a_ready}, 32'h1);
    chk(d_valid == 1'b0, "R11", "reset d_valid", {31'b0, d_valid}, 32'h0);
    chk(dev_req == 1'b0, "R9", "reset dev_req", {31'b0, dev_req}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // back-pressure and repeated same-address request
    @(negedge clk);
    drive(3'd4, 2'd2, 4'hF, 12'h00C, 1'b0);
    d_ready = 1'b0;
    @(negedge clk);
    a_data = 32'h1234_5678;
    a_opcode = 3'd0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(d_valid == 1'b1, "R11", "held d_valid", {31'b0, d_valid}, 32'h1);
      chk(d_data == {8'h5A, 12'h3C3, 12'h00C}, "R11", "held d_data", d_data,
          {8'h5A, 12'h3C3, 12'h00C});
      chk(a_ready == 1'b0, "R12", "ready while pending", {31'b0, a_ready}, 32'h0);
      chk(dev_req == 1'b0, "R12", "second req blocked", {31'b0, dev_req}, 32'h0);
      @(negedge clk);
    end
    d_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(d_valid == 1'b0, "R11", "released d_valid", {31'b0, d_valid}, 32'h0);
    chk(a_ready == 1'b1, "R12", "ready after handshake", {31'b0, a_ready}, 32'h1);
    chk(dev_req == 1'b1, "R12", "second req taken", {31'b0, dev_req}, 32'h1);
    chk(dev_wdata == 32'h1234_5678, "R10", "second wdata", dev_wdata, 32'h1234_5678);
    @(negedge clk);
    a_valid = 1'b0;
    #1;
    chk(d_valid == 1'b1 && d_error == 1'b0, "R11", "second response",
        {30'b0, d_valid, d_error}, 32'h2);
    chk(d_opcode == 3'd0 && d_data == 32'h0, "R10", "write response",
        {d_data[28:0], d_opcode}, 32'h0);
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule